// File: doc/BRIEF.md
# Pin Event Detector with Interrupt and DMA Routing

This block watches a bank of input pins and records, per pin, whether a configured event has happened. Each pin has its own 4-bit event code that selects what counts as an event (a rising edge, a falling edge, either edge, a low level or a high level) and where a recorded event is routed: to a per-pin DMA request, to one combined interrupt line, or nowhere (recorded only). Pin levels are first brought into the block clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized level with the synchronized level from the previous cycle.

Recorded events live in a status vector where bit n belongs to pin n. Software clears bits by writing ones through a write strobe and a mask. A per-pin DMA completion input clears the bit of a pin whose code selects DMA routing. A level condition that is still present records itself again at once, so a clear cannot remove it. When a detection and a clear hit the same bit in the same cycle, the detection wins.

Top module: `pin_event_detector`

## Requirements
- R1: Code 0 and the unused codes 4, 13, 14 and 15 never set a status bit, whatever the pin does.
- R2: Codes 1, 2 and 3 set the status bit on a rising edge, a falling edge and either edge. While the bit is set, `dma_req_o[n]` is 1. Such a pin never drives `irq_o`.
- R3: Codes 5, 6 and 7 set the status bit on a rising edge, a falling edge and either edge. Such a pin drives neither `irq_o` nor its DMA request.
- R4: Codes 9, 10 and 11 set the status bit on a rising edge, a falling edge and either edge. `irq_o` is the OR of all status bits whose pin code is in the range 8 to 12.
- R5: Code 8 sets the status bit whenever the synchronized level is 0. Code 12 sets it whenever the level is 1. While the level persists, the bit sets again in the cycle after any clear, and so it stays 1.
- R6: On a cycle with `clr_we_i` high, each 1 in `clr_mask_i` clears the matching status bit and each 0 leaves its bit unchanged. With `clr_we_i` low the mask has no effect.
- R7: `dma_done_i[n]` clears status bit n only when pin n's code is 1, 2 or 3. For any other code it has no effect.
- R8: Status bit n reports pin n (for example, 0x80010001 means pins 0, 16 and 31). A pin change driven between clock edges shows in `flags_o` after the third following rising clock edge, and not before.
- R9: If a detection and a clear (software or DMA completion) hit the same bit in the same cycle, the bit is 1 afterwards.
- R10: After reset, `flags_o`, `dma_req_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| cfg_code_i | input | NUM_PINS*4 | Event code of pin n in bits [4n+3:4n] |
| clr_we_i | input | 1 | Software clear strobe |
| clr_mask_i | input | NUM_PINS | Write-one-to-clear mask, used with clr_we_i |
| dma_done_i | input | NUM_PINS | DMA transfer completion per pin |
| flags_o | output | NUM_PINS | Status vector, bit n for pin n |
| dma_req_o | output | NUM_PINS | DMA request per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default 32 pins and two synchronizer stages, so the status vector reaches its full width. With that build, pins 0, 16 and 31 are checked for the bit mapping at both ends and in the middle of the vector. The two-stage synchronizer gives a fixed three-edge latency, and the bench checks one edge before that point and at that point. Because each pin has its own code, one stimulus can put pins in DMA, flag-only, interrupt and disabled modes side by side, and the bench then checks that the outputs stay separate.

// File: rtl/pevt_pkg.sv
package pevt_pkg;

    localparam int unsigned CODE_W = 4;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic on_low;
        logic on_high;
        logic to_dma;
        logic to_irq;
    } evt_mode_t;

    typedef struct packed {
        logic prev;
        logic flag;
    } cell_state_t;

    function automatic evt_mode_t decode_code(input logic [CODE_W-1:0] code);
        evt_mode_t m;
        m = '0;
        case (code)
            4'd1:  begin m.on_rise = 1'b1; m.to_dma = 1'b1; end
            4'd2:  begin m.on_fall = 1'b1; m.to_dma = 1'b1; end
            4'd3:  begin m.on_rise = 1'b1; m.on_fall = 1'b1; m.to_dma = 1'b1; end
            4'd5:  m.on_rise = 1'b1;
            4'd6:  m.on_fall = 1'b1;
            4'd7:  begin m.on_rise = 1'b1; m.on_fall = 1'b1; end
            4'd8:  begin m.on_low = 1'b1; m.to_irq = 1'b1; end
            4'd9:  begin m.on_rise = 1'b1; m.to_irq = 1'b1; end
            4'd10: begin m.on_fall = 1'b1; m.to_irq = 1'b1; end
            4'd11: begin m.on_rise = 1'b1; m.on_fall = 1'b1; m.to_irq = 1'b1; end
            4'd12: begin m.on_high = 1'b1; m.to_irq = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pevt_sync.sv
module pevt_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pevt_cell.sv
module pevt_cell
    import pevt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              sw_clr_i,
    input  logic              dma_done_i,
    output logic              flag_o,
    output logic              dma_req_o,
    output logic              irq_req_o
);
    evt_mode_t   mode;
    cell_state_t st_d, st_q;
    logic        rise, fall, hit, clr;

    always_comb begin
        mode = decode_code(code_i);
        rise = level_i & ~st_q.prev;
        fall = ~level_i & st_q.prev;
        hit  = (mode.on_rise & rise) | (mode.on_fall & fall) |
               (mode.on_low & ~level_i) | (mode.on_high & level_i);
        clr  = sw_clr_i | (dma_done_i & mode.to_dma);
        st_d.prev = level_i;
        if (hit)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
        else          st_d.flag = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o    = st_q.flag;
    assign dma_req_o = st_q.flag & mode.to_dma;
    assign irq_req_o = st_q.flag & mode.to_irq;

    // R1: a code that selects no event keeps a clear flag clear
    assert_idle_code_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && (code_i == 4'd0 || code_i == 4'd4 || code_i >= 4'd13)) |=> !flag_o);

    // R2: a DMA request only comes from a recorded event
    assert_dma_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> flag_o);

    // R5: a persisting low level under code 8 holds the flag
    assert_level_low_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 4'd8 && !level_i) |=> flag_o);

    // R7: completion clears a DMA-mode flag when no new event arrives
    assert_dma_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done_i && mode.to_dma && !hit) |=> !flag_o);

    // R9: a detection beats any clear in the same cycle
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> flag_o);
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
    import pevt_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_i,
    input  logic [NUM_PINS*CODE_W-1:0] cfg_code_i,
    input  logic                       clr_we_i,
    input  logic [NUM_PINS-1:0]        clr_mask_i,
    input  logic [NUM_PINS-1:0]        dma_done_i,
    output logic [NUM_PINS-1:0]        flags_o,
    output logic [NUM_PINS-1:0]        dma_req_o,
    output logic                       irq_o
);
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] irq_vec;
    logic [NUM_PINS-1:0] sw_clr;

    pevt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (level)
    );

    assign sw_clr = clr_we_i ? clr_mask_i : '0;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_cell
        pevt_cell cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (level[n]),
            .code_i    (cfg_code_i[n*CODE_W +: CODE_W]),
            .sw_clr_i  (sw_clr[n]),
            .dma_done_i(dma_done_i[n]),
            .flag_o    (flags_o[n]),
            .dma_req_o (dma_req_o[n]),
            .irq_req_o (irq_vec[n])
        );
    end

    assign irq_o = |irq_vec;

    // R4: no interrupt without at least one recorded event
    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o != '0));

    // R6: without the strobe the mask alone clears nothing
    assert_mask_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && dma_done_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: tb/pin_event_detector_tb_top.sv
module pin_event_detector_tb_top;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic [NP*4-1:0] cfg_code_i = '0;
    logic          clr_we_i = 1'b0;
    logic [NP-1:0] clr_mask_i = '0;
    logic [NP-1:0] dma_done_i = '0;
    logic [NP-1:0] flags_o, dma_req_o;
    logic          irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_event_detector #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_code_i(cfg_code_i),
        .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .dma_done_i(dma_done_i),
        .flags_o(flags_o), .dma_req_o(dma_req_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic set_code(input int pin, input logic [3:0] code);
        cfg_code_i[pin*4 +: 4] = code;
    endtask

    task automatic sw_clear(input logic [NP-1:0] mask);
        clr_we_i = 1'b1;
        clr_mask_i = mask;
        tick(1);
        clr_we_i = 1'b0;
        clr_mask_i = '0;
    endtask

    task automatic settle();
        cfg_code_i = '0;
        pin_i = '0;
        tick(4);
        sw_clear('1);
    endtask

    task automatic t_reset();
        check("R10 flags", flags_o, 0);
        check("R10 dma", dma_req_o, 0);
        check("R10 irq", irq_o, 0);
    endtask

    task automatic t_disabled();
        set_code(0, 0); set_code(1, 4); set_code(2, 13); set_code(3, 14); set_code(4, 15);
        pin_i[4:0] = 5'h1f;
        tick(4);
        pin_i[4:0] = 5'h00;
        tick(4);
        check("R1 flags", flags_o, 0);
        check("R1 irq", irq_o, 0);
        settle();
    endtask

    task automatic t_dma();
        set_code(1, 1); set_code(2, 2); set_code(3, 3);
        pin_i[3:1] = 3'b111;
        tick(3);
        check("R2 rise flags", flags_o, 32'h0000_000a);
        check("R2 rise dma", dma_req_o, 32'h0000_000a);
        check("R2 no irq", irq_o, 0);
        pin_i[3:1] = 3'b000;
        tick(3);
        check("R2 fall flags", flags_o, 32'h0000_000e);
        check("R2 fall dma", dma_req_o, 32'h0000_000e);
        settle();
    endtask

    task automatic t_flag_only();
        set_code(5, 5); set_code(6, 6); set_code(7, 7);
        pin_i[7:5] = 3'b111;
        tick(3);
        check("R3 rise flags", flags_o, 32'h0000_00a0);
        pin_i[7:5] = 3'b000;
        tick(3);
        check("R3 fall flags", flags_o, 32'h0000_00e0);
        check("R3 no irq", irq_o, 0);
        check("R3 no dma", dma_req_o, 0);
        settle();
    endtask

    task automatic t_irq_edges();
        set_code(9, 9); set_code(10, 10); set_code(11, 11);
        pin_i[11:9] = 3'b111;
        tick(3);
        check("R4 rise flags", flags_o, 32'h0000_0a00);
        check("R4 irq", irq_o, 1);
        check("R4 no dma", dma_req_o, 0);
        pin_i[11:9] = 3'b000;
        tick(3);
        check("R4 fall flags", flags_o, 32'h0000_0e00);
        sw_clear(32'h0000_0e00);
        check("R4 irq drops", irq_o, 0);
        settle();
    endtask

    task automatic t_level();
        set_code(8, 8);
        tick(1);
        check("R5 low sets", flags_o, 32'h0000_0100);
        check("R5 irq", irq_o, 1);
        sw_clear(32'h0000_0100);
        check("R5 re-set after clear", flags_o, 32'h0000_0100);
        pin_i[8] = 1'b1;
        tick(3);
        sw_clear(32'h0000_0100);
        check("R5 cleared once high", flags_o, 0);
        set_code(12, 12);
        pin_i[12] = 1'b1;
        tick(3);
        check("R5 high sets", flags_o, 32'h0000_1000);
        check("R5 high irq", irq_o, 1);
        settle();
    endtask

    task automatic t_w1c();
        set_code(0, 7); set_code(16, 7); set_code(31, 7);
        pin_i[0] = 1'b1; pin_i[16] = 1'b1; pin_i[31] = 1'b1;
        tick(3);
        check("R8 bit map", flags_o, 32'h8001_0001);
        clr_we_i = 1'b0;
        clr_mask_i = '1;
        tick(1);
        clr_mask_i = '0;
        check("R6 mask without strobe", flags_o, 32'h8001_0001);
        sw_clear(32'h0001_0000);
        check("R6 partial clear", flags_o, 32'h8000_0001);
        sw_clear(32'h7fff_fffe);
        check("R6 zero bits keep", flags_o, 32'h8000_0001);
        settle();
    endtask

    task automatic t_latency();
        set_code(20, 9);
        pin_i[20] = 1'b1;
        tick(2);
        check("R8 not before third edge", flags_o, 0);
        tick(1);
        check("R8 at third edge", flags_o, 32'h0010_0000);
        settle();
    endtask

    task automatic t_dma_done();
        set_code(21, 1); set_code(22, 5);
        pin_i[21] = 1'b1; pin_i[22] = 1'b1;
        tick(3);
        check("R7 both set", flags_o, 32'h0060_0000);
        dma_done_i[21] = 1'b1; dma_done_i[22] = 1'b1;
        tick(1);
        dma_done_i = '0;
        check("R7 only dma pin cleared", flags_o, 32'h0040_0000);
        check("R7 dma req off", dma_req_o, 0);
        settle();
    endtask

    task automatic t_set_wins();
        set_code(24, 9);
        pin_i[24] = 1'b1;
        tick(2);
        sw_clear(32'h0100_0000);
        check("R9 set beats clear", flags_o, 32'h0100_0000);
        sw_clear(32'h0100_0000);
        check("R9 later clear works", flags_o, 0);
        settle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_disabled();
        t_dma();
        t_flag_only();
        t_irq_edges();
        t_level();
        t_w1c();
        t_latency();
        t_dma_done();
        t_set_wins();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule